// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block sends bytes onto a two-wire serial bus as the bus master. A host sets it to master transmit mode through a small register file, then asks for a start condition by writing a bus command pair: a busy request bit and a qualifier bit. Bytes go through a data register that is copied into a shift register, so the host can load the next byte while the current byte is still being sent. The first byte after a start is the 7-bit slave address plus the read/write bit. The remaining bytes are payload.

The host watches four status bits: data register empty, transfer end, received acknowledge, and stop seen. The block only pulls its clock and data lines low (open-drain style), and the bus pull-ups take care of the high level. A line monitor tracks start and stop conditions on the bus, including those from other masters, and reports them through a bus-busy bit. The clock half-period is set in system clock cycles by a divider register.

Top module: `i2c_master_tx`

## Requirements
- R1: With mode register (address 0) holding master=1 (bit 1) and transmit=1 (bit 0), and the bus idle, a write to address 1 with busy request=1 (bit 1) and qualifier=0 (bit 0) produces a start condition: SDA falls while SCL is high. After that, bus busy (address 1 bit 1) reads 1.
- R2: A start request has no effect on SCL or SDA in each of these cases: the bus is already busy, the mode is not master transmit, or the qualifier bit is 1.
- R3: Each byte is sent MSB first, as 8 clocks followed by a ninth acknowledge clock. During a data bit, SDA holds steady while SCL is high.
- R4: Data empty (address 2 bit 0) sets when the data register (address 3) is copied into the shift register. A write to address 3 clears it.
- R5: Transfer end (address 2 bit 1) sets when the ninth clock of a byte completes and no new byte is waiting. It stays 0 through a back-to-back transfer whose next byte was already written.
- R6: The level sampled on SDA at the ninth clock is kept in address 2 bit 3: 0 means acknowledge, 1 means no acknowledge.
- R7: A write to address 1 with busy request=0 and qualifier=0 while the bus is busy in master transmit mode makes a stop condition once the current byte is done. Stop seen (address 2 bit 2) then sets and bus busy reads 0.
- R8: Writing 0 to status bits 0 to 2 clears them. Writing 1 leaves them unchanged.
- R9: The SCL period is 2*max(D,4) system clocks, where D is the divider register (address 4).
- R10: Bus busy also follows start and stop conditions made by other devices on the bus, and stop seen sets on any stop.
- R11: After reset, SCL and SDA are released, the mode, bus and status registers read 0, and the divider reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host register write strobe |
| addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data for addr (combinational) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The main transmit path is tested with four patterns. A single byte that gets an acknowledge checks the start, the bit order and transfer end. A back-to-back pair checks that the data empty flag refills the buffer without raising transfer end. A byte with no acknowledge shows that the ninth-clock sample is really taken from the line and not fixed at 0. A start and stop made by another device on the bus shows that bus busy comes from the line monitor and not from the block's own state, and that a start request on a busy bus is refused. Divider settings below and above the minimum show whether the clamp and the period formula hold.

// File: rtl/i2c_mt_pkg.sv
package i2c_mt_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int MIN_HALF = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_BUS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_STA1, S_STA2, S_HOLD, S_BLO, S_BHI, S_STP1, S_STP2, S_STP3
  } eng_state_t;

  // clock half-period in system cycles, with a lower bound
  function automatic int unsigned half_cycles(input int unsigned div);
    return (div < MIN_HALF) ? MIN_HALF : div;
  endfunction
endpackage

// File: rtl/i2c_mt_busmon.sv
module i2c_mt_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic bus_busy
);
  logic [SYNC-1:0] scl_sr, sda_sr;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s    = scl_sr[SYNC-1];
  assign sda_s    = sda_sr[SYNC-1];
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_busy <= 1'b0;
    else if (ev_start) bus_busy <= 1'b1;
    else if (ev_stop)  bus_busy <= 1'b0;
  end

  // R10: busy follows observed line conditions
  a_r10_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> bus_busy);
  a_r10_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !bus_busy);
endmodule

// File: rtl/i2c_mt_engine.sv
module i2c_mt_engine
  import i2c_mt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              dr_full,
  input  logic [BYTE_W-1:0] dr_data,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              start_ack,
  output logic              stop_ack,
  output logic              ev_load,
  output logic              ev_byte_done,
  output logic              idle
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);

  eng_state_t        state;
  logic [DIV_W-1:0]  cnt, reload;
  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     bitcnt;
  logic              sda_drv;
  logic              tick;
  logic              in_data_high;

  assign reload = DIV_W'(half_cycles(32'(div)) - 1);
  assign tick   = (cnt == '0);

  assign idle         = (state == S_IDLE);
  assign start_ack    = (state == S_IDLE) && start_req;
  assign ev_load      = (state == S_HOLD) && dr_full;
  assign stop_ack     = (state == S_HOLD) && !dr_full && stop_req;
  assign ev_byte_done = (state == S_BHI) && tick && (bitcnt == LAST);
  assign in_data_high = (state == S_BHI);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (state)
      S_STA1:        sda_oe = 1'b1;
      S_STA2:        begin scl_oe = 1'b1; sda_oe = 1'b1; end
      S_HOLD:        scl_oe = 1'b1;
      S_BLO:         begin scl_oe = 1'b1; sda_oe = sda_drv; end
      S_BHI:         sda_oe = sda_drv;
      S_STP1:        begin scl_oe = 1'b1; sda_oe = 1'b1; end
      S_STP2:        sda_oe = 1'b1;
      default:       ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      bitcnt  <= '0;
      sda_drv <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_req) begin state <= S_STA1; cnt <= reload; end
        S_STA1: if (tick) begin state <= S_STA2; cnt <= reload; end
                else cnt <= cnt - 1'b1;
        S_STA2: if (tick) state <= S_HOLD;
                else cnt <= cnt - 1'b1;
        S_HOLD: begin
          if (dr_full) begin
            sh     <= dr_data;
            bitcnt <= '0;
            state  <= S_BLO;
            cnt    <= reload;
          end else if (stop_req) begin
            state <= S_STP1;
            cnt   <= reload;
          end
        end
        S_BLO: begin
          // data changes one cycle after SCL has gone low
          sda_drv <= (bitcnt == LAST) ? 1'b0 : ~sh[BYTE_W-1];
          if (tick) begin state <= S_BHI; cnt <= reload; end
          else cnt <= cnt - 1'b1;
        end
        S_BHI: begin
          if (tick) begin
            if (bitcnt == LAST) state <= S_HOLD;
            else begin
              sh     <= sh << 1;
              bitcnt <= bitcnt + 1'b1;
              state  <= S_BLO;
              cnt    <= reload;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_STP1: if (tick) begin state <= S_STP2; cnt <= reload; end
                else cnt <= cnt - 1'b1;
        S_STP2: if (tick) begin state <= S_STP3; cnt <= reload; end
                else cnt <= cnt - 1'b1;
        S_STP3: if (tick) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: SDA steady while SCL is released during a data bit
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_high && $past(in_data_high)) |-> $stable(sda_oe));
  // R1: start sequence only entered from idle on a request
  a_r1_start_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STA1 && $past(state) != S_STA1) |-> $past(state == S_IDLE && start_req));
  // R7: stop only after a finished byte with a stop pending
  a_r7_stop_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STP1 && $past(state) != S_STP1) |-> $past(state == S_HOLD && stop_req));
endmodule

// File: rtl/i2c_mt_regs.sv
module i2c_mt_regs
  import i2c_mt_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              bus_busy,
  input  logic              ev_stop,
  input  logic              sda_s,
  input  logic              eng_idle,
  input  logic              start_ack,
  input  logic              stop_ack,
  input  logic              ev_load,
  input  logic              ev_byte_done,
  output logic [DIV_W-1:0]  div,
  output logic              start_req,
  output logic              stop_req,
  output logic              dr_full,
  output logic [BYTE_W-1:0] dr_data
);
  logic mode_master, mode_xmit;
  logic tx_empty, tx_end, stop_seen, ack_bit;
  logic wr_mode, wr_bus, wr_stat, wr_data_reg, wr_div;
  logic mt_mode, start_ok, stop_ok;

  assign wr_mode     = wr_en && (addr == A_MODE);
  assign wr_bus      = wr_en && (addr == A_BUS);
  assign wr_stat     = wr_en && (addr == A_STAT);
  assign wr_data_reg = wr_en && (addr == A_DATA);
  assign wr_div      = wr_en && (addr == A_DIV);
  assign mt_mode     = mode_master && mode_xmit;
  assign start_ok    = wr_bus && (wr_data[1:0] == 2'b10) && mt_mode &&
                       !bus_busy && eng_idle && !start_req;
  assign stop_ok     = wr_bus && (wr_data[1:0] == 2'b00) && mt_mode && bus_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_master <= 1'b0;
      mode_xmit   <= 1'b0;
      div         <= DIV_RESET;
      start_req   <= 1'b0;
      stop_req    <= 1'b0;
      dr_full     <= 1'b0;
      dr_data     <= '0;
      tx_empty    <= 1'b0;
      tx_end      <= 1'b0;
      stop_seen   <= 1'b0;
      ack_bit     <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_master <= wr_data[1];
        mode_xmit   <= wr_data[0];
      end
      if (wr_div) div <= wr_data[DIV_W-1:0];

      if (start_ok)       start_req <= 1'b1;
      else if (start_ack) start_req <= 1'b0;
      if (stop_ok)        stop_req  <= 1'b1;
      else if (stop_ack)  stop_req  <= 1'b0;

      // flag clears first, hardware sets take priority
      if (wr_stat) begin
        if (!wr_data[0]) tx_empty  <= 1'b0;
        if (!wr_data[1]) tx_end    <= 1'b0;
        if (!wr_data[2]) stop_seen <= 1'b0;
      end

      if (wr_data_reg) begin
        dr_data  <= wr_data;
        dr_full  <= 1'b1;
        tx_empty <= 1'b0;
      end else if (ev_load) begin
        dr_full  <= 1'b0;
        tx_empty <= 1'b1;
      end

      if (ev_byte_done) begin
        ack_bit <= sda_s;
        if (!dr_full) tx_end <= 1'b1;
      end
      if (ev_stop) stop_seen <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rd_data = {6'b0, mode_master, mode_xmit};
      A_BUS:   rd_data = {6'b0, bus_busy, 1'b0};
      A_STAT:  rd_data = {4'b0, ack_bit, stop_seen, tx_end, tx_empty};
      A_DATA:  rd_data = dr_data;
      A_DIV:   rd_data = BYTE_W'(div);
      default: rd_data = '0;
    endcase
  end

  // R1: a start is only latched for an idle bus in master transmit mode
  a_r1_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_req) |-> $past(!bus_busy && mt_mode));
  // R5: transfer end only rises when no byte was waiting
  a_r5_end_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> $past(!dr_full));
  // R4: a copy into the shifter raises data empty
  a_r4_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !wr_data_reg) |=> tx_empty);
  // R8: writing 1 to a flag leaves it as it was
  a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[1] && !ev_byte_done) |=> (tx_end == $past(tx_end)));
endmodule

// File: rtl/i2c_master_tx.sv
module i2c_master_tx
  import i2c_mt_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 4,
  parameter int               SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic              sda_s, ev_start, ev_stop, bus_busy;
  logic [DIV_W-1:0]  div;
  logic              start_req, stop_req, dr_full;
  logic [BYTE_W-1:0] dr_data;
  logic              start_ack, stop_ack, ev_load, ev_byte_done, eng_idle;

  i2c_mt_busmon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop), .bus_busy(bus_busy)
  );

  i2c_mt_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .bus_busy(bus_busy), .ev_stop(ev_stop), .sda_s(sda_s),
    .eng_idle(eng_idle), .start_ack(start_ack), .stop_ack(stop_ack),
    .ev_load(ev_load), .ev_byte_done(ev_byte_done), .div(div),
    .start_req(start_req), .stop_req(stop_req), .dr_full(dr_full), .dr_data(dr_data)
  );

  i2c_mt_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .div(div), .start_req(start_req),
    .stop_req(stop_req), .dr_full(dr_full), .dr_data(dr_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .start_ack(start_ack), .stop_ack(stop_ack),
    .ev_load(ev_load), .ev_byte_done(ev_byte_done), .idle(eng_idle)
  );

  // R11: lines released while no transfer is in progress after reset
  a_r11_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !start_req && $past(eng_idle)) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/test_i2c_master_tx.sv
`timescale 1ns/1ps
module test_i2c_master_tx;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic scl_oe, sda_oe;
  logic slv_ack_low = 0, ext_sda_low = 0, ack_en = 1;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_ack_low | ext_sda_low);

  int checks = 0, errors = 0;
  int bitpos = 0, rx_n = 0, starts = 0, stops = 0;
  logic [7:0] cur = 0;
  logic [7:0] rx [0:15];
  realtime last_rise = 0, period = 0;

  always #5 clk = ~clk;

  i2c_master_tx i_i2c_master_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // slave model
  always @(negedge sda_line) if (scl_line) begin starts++; bitpos = 0; end
  always @(posedge sda_line) if (scl_line) stops++;
  always @(posedge scl_line) begin
    period = $realtime - last_rise;
    last_rise = $realtime;
    if (bitpos < 8) begin cur = {cur[6:0], sda_line}; bitpos++; end
    else begin rx[rx_n[3:0]] = cur; rx_n++; bitpos = 0; end
  end
  always @(negedge scl_line) slv_ack_low = (bitpos == 8) && ack_en;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic poll(input logic [2:0] a, input int b, input logic v, output bit ok);
    logic [7:0] d;
    ok = 0;
    for (int i = 0; i < 8000; i++) begin
      rd(a, d);
      if (d[b] == v) begin ok = 1; break; end
    end
  endtask

  task automatic do_stop(input string req);
    bit ok;
    logic [7:0] d;
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
    poll(3'd2, 2, 1'b1, ok);
    chk({req, " stop seen"}, ok, 1);
    rd(3'd1, d);
    chk({req, " busy cleared"}, d[1], 0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk("R11 mode", d, 8'h00);
    rd(3'd1, d); chk("R11 bus", d, 8'h00);
    rd(3'd2, d); chk("R11 status", d, 8'h00);
    rd(3'd4, d); chk("R11 divider", d, 8'h04);
    chk("R11 lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_refused;
    logic [7:0] d;
    int s0 = starts;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h02);
    repeat (60) @(negedge clk);
    chk("R2 not master", {scl_oe, sda_oe, 6'(starts - s0)}, 0);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h03);
    repeat (60) @(negedge clk);
    chk("R2 qualifier set", {scl_oe, sda_oe, 6'(starts - s0)}, 0);
    rd(3'd1, d); chk("R2 bus idle", d[1], 0);
  endtask

  task automatic t_single;
    bit ok;
    logic [7:0] d;
    int s0 = starts, n0 = rx_n, p0 = stops;
    ack_en = 1;
    wr(3'd0, 8'h03);
    wr(3'd3, 8'hA6);
    wr(3'd1, 8'h02);
    poll(3'd1, 1, 1'b1, ok);
    chk("R1 busy after start", ok, 1);
    chk("R1 start on line", starts - s0, 1);
    poll(3'd2, 0, 1'b1, ok);
    chk("R4 empty after copy", ok, 1);
    poll(3'd2, 1, 1'b1, ok);
    chk("R5 end after byte", ok, 1);
    chk("R3 byte MSB first", rx[n0[3:0]], 8'hA6);
    rd(3'd2, d);
    chk("R6 ack captured", d[3], 0);
    chk("R9 default period", int'(period), 80);
    wr(3'd2, 8'b1111_1101);
    rd(3'd2, d);
    chk("R8 one keeps, zero clears", d[2:0], 3'b001);
    do_stop("R7");
    chk("R7 stop on line", stops - p0, 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_b2b;
    bit ok;
    logic [7:0] d;
    int n0 = rx_n;
    wr(3'd0, 8'h03);
    wr(3'd3, 8'h3C);
    wr(3'd1, 8'h02);
    poll(3'd2, 0, 1'b1, ok);
    wr(3'd3, 8'h5A);
    rd(3'd2, d);
    chk("R4 data write clears empty", d[0], 0);
    poll(3'd2, 0, 1'b1, ok);
    rd(3'd2, d);
    chk("R5 no end in back-to-back", d[1], 0);
    poll(3'd2, 1, 1'b1, ok);
    chk("R5 end after last byte", ok, 1);
    chk("R3 first byte", rx[n0[3:0]], 8'h3C);
    chk("R3 second byte", rx[4'(n0 + 1)], 8'h5A);
    do_stop("R7 b2b");
    wr(3'd0, 8'h00);
  endtask

  task automatic t_nack_div(input logic [7:0] dv, input int exp_ns);
    bit ok;
    logic [7:0] d;
    int n0 = rx_n;
    ack_en = 0;
    wr(3'd4, dv);
    wr(3'd0, 8'h03);
    wr(3'd3, 8'hC3);
    wr(3'd1, 8'h02);
    poll(3'd2, 1, 1'b1, ok);
    rd(3'd2, d);
    chk("R6 nack captured", d[3], 1);
    chk("R9 scl period", int'(period), exp_ns);
    chk("R3 byte content", rx[n0[3:0]], 8'hC3);
    do_stop("R7 nack");
    wr(3'd0, 8'h00);
    ack_en = 1;
  endtask

  task automatic t_external;
    logic [7:0] d;
    ext_sda_low = 1;
    repeat (10) @(negedge clk);
    rd(3'd1, d); chk("R10 busy from other master", d[1], 1);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h02);
    repeat (60) @(negedge clk);
    chk("R2 start refused when busy", scl_oe, 0);
    ext_sda_low = 0;
    repeat (10) @(negedge clk);
    rd(3'd1, d); chk("R10 idle after other stop", d[1], 0);
    rd(3'd2, d); chk("R10 stop seen", d[2], 1);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_refused;
    t_single;
    t_b2b;
    t_nack_div(8'd10, 200);
    t_nack_div(8'd2, 80);
    t_external;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule